// File: doc/BRIEF.md
# Asynchronous Schedule Sleep Controller

This block decides when a USB host controller walks its asynchronous (bulk and control) schedule, and when it stops walking it. It watches the queue-head visit events reported by the fetch logic. Each visit carries a flag that says whether the visited queue head is the marked list head. A separate strobe reports that a transaction was executed. From these events the block tracks a reclamation flag. The flag tells it whether the last full pass around the circular list did any useful work.

If a whole pass ends with no work done, the block stops issuing traversal requests. It then sleeps for a programmable number of 125 µs microframe ticks. When the sleep ends, it restarts from the schedule start condition and pulses a reload of the per-endpoint NAK counters, so that endpoints which were NAKing get a fresh chance. An end-of-microframe event during traversal hands control to the periodic schedule. Traversal resumes where it left off once the periodic side reports completion. Clearing the schedule enable returns the block to idle from any state.

Top module: `async_sleep_ctrl`

## Requirements
- R1: After reset, `asyncReq`, `asleep`, `periodicReq` and `nakReload` are all 0, and the block is idle.
- R2: When `schedEn` is 1 in idle, the block enters the active state. From the next cycle `asyncReq` is 1, and `nakReload` is 1 for exactly that one cycle. The reclamation flag is primed to 1, so the first head visit after entry does not count as empty.
- R3: While the block is active, `txnDone` sets the reclamation flag. A visit (`qhVisit`) with `qhHead`=1 clears the flag. A head visit finds the list empty only if the flag was already 0 and `txnDone` is 0 in the same cycle. A transaction in the same cycle as the head visit leaves the flag at 1.
- R4: On an empty-list decision, the block enters sleep in the next cycle. There `asyncReq` is 0 and `asleep` is 1.
- R5: The sleep lasts `sleepTicks` microframe ticks (`uframeTick`). The block wakes at the edge that samples the N-th tick. A `sleepTicks` value of 0 selects the parameter default `DEF_SLEEP_TICKS`, which is 80 ticks (10 ms).
- R6: On wake, the block returns to active with `asyncReq`=1. `nakReload` pulses for one cycle, and the reclamation flag is primed to 1 again.
- R7: An active-state `uframeEnd` gives a one-cycle `periodicReq` pulse and drops `asyncReq`. The block then waits for `periodicDone` and resumes active, with no NAK reload and with the reclamation flag unchanged.
- R8: If `uframeEnd` and an empty-list decision fall in the same cycle, the periodic hand-off wins and no sleep is started.
- R9: With `schedEn`=0, the block goes to idle at the next edge from any state (`asyncReq`=0, `asleep`=0). The sleep timer and the reclamation flag are cleared, so a later sleep counts its full interval from the start.
- R10: While the block is asleep, `uframeEnd` and `periodicDone` have no effect. Ticks outside sleep do not change the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| schedEn | input | 1 | Asynchronous schedule enable |
| qhVisit | input | 1 | A queue head was visited this cycle |
| qhHead | input | 1 | The visited queue head carries the list-head mark |
| txnDone | input | 1 | A transaction was executed this cycle |
| uframeEnd | input | 1 | End-of-microframe event |
| uframeTick | input | 1 | One pulse every 125 µs microframe |
| periodicDone | input | 1 | Periodic schedule finished; asynchronous traversal may resume |
| sleepTicks | input | TICK_W | Sleep interval in microframe ticks (0 selects default) |
| asyncReq | output | 1 | Request to keep traversing the asynchronous list |
| asleep | output | 1 | Block is in the schedule-sleep state |
| periodicReq | output | 1 | One-cycle pulse: attempt the periodic schedule |
| nakReload | output | 1 | One-cycle pulse: reload per-endpoint NAK counters |

## Verification
The hardest case to reach is the reclamation flag surviving a periodic hand-off. A head visit clears the flag, then `uframeEnd` suspends traversal, then `periodicDone` resumes it. The very next head visit must be declared empty without any reload. The stimulus builds this sequence cycle by cycle. It also creates the same-cycle collisions: end-of-microframe together with an empty head visit, and a transaction together with a head visit. The full 80-tick default interval is counted out one tick short and then one tick exactly.

// File: rtl/async_sleep_pkg.sv
package async_sleep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ACTIVE   = 2'd1,
    ST_PERIODIC = 2'd2,
    ST_SLEEP    = 2'd3
  } schedState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic trackEn;    // follow visit / transaction events
    logic clearAll;   // drop flag and timer
    logic primeFlag;  // force reclamation flag to 1
    logic loadTimer;  // load sleep interval
    logic stepTimer;  // timer may count ticks
  } dpCtl_t;

endpackage

// File: rtl/asc_datapath.sv
module asc_datapath
  import async_sleep_pkg::*;
#(
  parameter int TICK_W          = 8,
  parameter int DEF_SLEEP_TICKS = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              qhVisit,
  input  logic              qhHead,
  input  logic              txnDone,
  input  logic              uframeTick,
  input  logic [TICK_W-1:0] sleepTicks,
  output logic              emptyDet,
  output logic              timerExpire
);

  localparam logic [TICK_W-1:0] DEF_VAL = TICK_W'(DEF_SLEEP_TICKS);
  localparam logic [TICK_W-1:0] ONE     = TICK_W'(1);

  logic              reclaim;
  logic [TICK_W-1:0] count;
  logic [TICK_W-1:0] loadVal;
  logic              headSeen;

  assign headSeen = ctl.trackEn && qhVisit && qhHead;
  assign emptyDet = headSeen && !reclaim && !txnDone;
  assign loadVal  = (sleepTicks == '0) ? DEF_VAL : sleepTicks;
  assign timerExpire = ctl.stepTimer && uframeTick && (count <= ONE);

  // reclamation flag
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      reclaim <= 1'b0;
    end else if (ctl.primeFlag) begin
      reclaim <= 1'b1;
    end else if (ctl.trackEn) begin
      if (txnDone)       reclaim <= 1'b1;
      else if (headSeen) reclaim <= 1'b0;
    end
  end

  // sleep interval counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      count <= '0;
    end else if (ctl.loadTimer) begin
      count <= loadVal;
    end else if (timerExpire) begin
      count <= '0;
    end else if (ctl.stepTimer && uframeTick) begin
      count <= count - ONE;
    end
  end

endmodule

// File: rtl/asc_control.sv
module asc_control
  import async_sleep_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   schedEn,
  input  logic   uframeEnd,
  input  logic   periodicDone,
  input  logic   emptyDet,
  input  logic   timerExpire,
  output dpCtl_t ctl,
  output logic   asyncReq,
  output logic   asleep,
  output logic   periodicReq,
  output logic   nakReload
);

  schedState_t state, stateNext;
  logic periodicNext, reloadNext;

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    periodicNext  = 1'b0;
    reloadNext    = 1'b0;
    ctl.trackEn   = (state == ST_ACTIVE);
    ctl.stepTimer = (state == ST_SLEEP);
    if (!schedEn) begin
      stateNext    = ST_IDLE;
      ctl.clearAll = 1'b1;
      ctl.trackEn  = 1'b0;
      ctl.stepTimer = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNext     = ST_ACTIVE;
          ctl.primeFlag = 1'b1;
          reloadNext    = 1'b1;
        end
        ST_ACTIVE: begin
          if (uframeEnd) begin
            stateNext    = ST_PERIODIC;
            periodicNext = 1'b1;
          end else if (emptyDet) begin
            stateNext     = ST_SLEEP;
            ctl.loadTimer = 1'b1;
          end
        end
        ST_PERIODIC: begin
          if (periodicDone) stateNext = ST_ACTIVE;
        end
        ST_SLEEP: begin
          if (timerExpire) begin
            stateNext     = ST_ACTIVE;
            ctl.primeFlag = 1'b1;
            reloadNext    = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      periodicReq <= 1'b0;
      nakReload   <= 1'b0;
    end else begin
      state       <= stateNext;
      periodicReq <= periodicNext;
      nakReload   <= reloadNext;
    end
  end

  assign asyncReq = (state == ST_ACTIVE);
  assign asleep   = (state == ST_SLEEP);

endmodule

// File: rtl/async_sleep_ctrl.sv
module async_sleep_ctrl
  import async_sleep_pkg::*;
#(
  parameter int TICK_W          = 8,
  parameter int DEF_SLEEP_TICKS = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              schedEn,
  input  logic              qhVisit,
  input  logic              qhHead,
  input  logic              txnDone,
  input  logic              uframeEnd,
  input  logic              uframeTick,
  input  logic              periodicDone,
  input  logic [TICK_W-1:0] sleepTicks,
  output logic              asyncReq,
  output logic              asleep,
  output logic              periodicReq,
  output logic              nakReload
);

  dpCtl_t ctl;
  logic   emptyDet;
  logic   timerExpire;

  asc_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .schedEn      (schedEn),
    .uframeEnd    (uframeEnd),
    .periodicDone (periodicDone),
    .emptyDet     (emptyDet),
    .timerExpire  (timerExpire),
    .ctl          (ctl),
    .asyncReq     (asyncReq),
    .asleep       (asleep),
    .periodicReq  (periodicReq),
    .nakReload    (nakReload)
  );

  asc_datapath #(
    .TICK_W          (TICK_W),
    .DEF_SLEEP_TICKS (DEF_SLEEP_TICKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .qhVisit     (qhVisit),
    .qhHead      (qhHead),
    .txnDone     (txnDone),
    .uframeTick  (uframeTick),
    .sleepTicks  (sleepTicks),
    .emptyDet    (emptyDet),
    .timerExpire (timerExpire)
  );

endmodule

// File: rtl/async_sleep_chk.sv
module async_sleep_chk (
  input logic clk,
  input logic rstN,
  input logic schedEn,
  input logic uframeEnd,
  input logic asyncReq,
  input logic asleep,
  input logic periodicReq,
  input logic nakReload
);

  // R4
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    asleep |-> !asyncReq);

  // R6
  wake_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (asyncReq && $past(asleep)) |-> nakReload);

  // R7
  periodic_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodicReq |=> !periodicReq);

  // R8
  eof_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (schedEn && asyncReq && uframeEnd) |=> (periodicReq && !asleep));

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !schedEn |=> (!asyncReq && !asleep));

  // R2
  reload_needs_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    nakReload |-> asyncReq);

endmodule

bind async_sleep_ctrl async_sleep_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .schedEn     (schedEn),
  .uframeEnd   (uframeEnd),
  .asyncReq    (asyncReq),
  .asleep      (asleep),
  .periodicReq (periodicReq),
  .nakReload   (nakReload)
);

// File: tb/sim_async_sleep_ctrl.sv
module sim_async_sleep_ctrl;

  localparam int TICK_W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic schedEn, qhVisit, qhHead, txnDone, uframeEnd, uframeTick, periodicDone;
  logic [TICK_W-1:0] sleepTicks;
  logic asyncReq, asleep, periodicReq, nakReload;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  async_sleep_ctrl #(.TICK_W(TICK_W), .DEF_SLEEP_TICKS(80)) u0 (
    .clk(clk), .rstN(rstN), .schedEn(schedEn), .qhVisit(qhVisit),
    .qhHead(qhHead), .txnDone(txnDone), .uframeEnd(uframeEnd),
    .uframeTick(uframeTick), .periodicDone(periodicDone),
    .sleepTicks(sleepTicks), .asyncReq(asyncReq), .asleep(asleep),
    .periodicReq(periodicReq), .nakReload(nakReload)
  );

  // {en,visit,head,txn,eof,tick,pdone, expAsync,expSleep,expPer,expReload}
  localparam int NV = 23;
  localparam logic [10:0] VEC [0:NV-1] = '{
    11'b1000000_1001, // R2 enter active
    11'b1110000_1000, // R2 primed, no empty
    11'b1001000_1000, // R3 txn sets flag
    11'b1110000_1000, // R3 head clears
    11'b1110000_0100, // R4 empty -> sleep
    11'b1000010_0100, // R5 tick 1
    11'b1000110_0100, // R10 eof ignored, tick 2
    11'b1000001_0100, // R10 pdone ignored
    11'b1000010_1001, // R5 R6 tick 3 wakes
    11'b1110000_1000, // R6 primed flag
    11'b1000100_0010, // R7 hand-off
    11'b1000000_0000, // R7 waiting
    11'b1000001_1000, // R7 resume, no reload
    11'b1110000_0100, // R7 flag kept -> empty
    11'b0000000_0000, // R9 disable
    11'b1000000_1001, // R2 re-enter
    11'b1110000_1000, // R3 clear
    11'b1110100_0010, // R8 eof beats empty
    11'b1000001_1000, // R7 resume
    11'b1111000_1000, // R3 txn with head visit
    11'b1110000_1000, // R3 clear
    11'b1110000_0100, // R4 empty
    11'b0000000_0000  // R9 sleep -> idle
  };

  task automatic check(input logic a, s, p, r, input string tag);
    tests++;
    if ({asyncReq, asleep, periodicReq, nakReload} !== {a, s, p, r}) begin
      fails++;
      $display("FAIL %s: got %b%b%b%b expected %b%b%b%b", tag,
               asyncReq, asleep, periodicReq, nakReload, a, s, p, r);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {schedEn, qhVisit, qhHead, txnDone, uframeEnd, uframeTick, periodicDone} = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    sleepTicks = 8'd3;
    {schedEn, qhVisit, qhHead, txnDone, uframeEnd, uframeTick, periodicDone} = '0;
    repeat (3) @(negedge clk);
    check(0, 0, 0, 0, "R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    check(0, 0, 0, 0, "R1 idle after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10:4]);
      check(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("table step %0d", i));
    end

    // R10: ticks while active leave timer untouched; R5 default of 80
    sleepTicks = 8'd0;
    drive(7'b1000000);
    check(1, 0, 0, 1, "R2 enable");
    for (int i = 0; i < 5; i++) drive(7'b1000010);
    check(1, 0, 0, 0, "R10 ticks in active");
    drive(7'b1110000);
    drive(7'b1110000);
    check(0, 1, 0, 0, "R4 sleep default");
    begin
      bit stayed = 1;
      for (int i = 0; i < 79; i++) begin
        drive(7'b1000010);
        if (!asleep) stayed = 0;
      end
      tests++;
      if (!stayed) begin
        fails++;
        $display("FAIL R5 default: got early wake expected asleep 79 ticks");
      end
    end
    drive(7'b1000010);
    check(1, 0, 0, 1, "R5 R6 wake at tick 80");

    // R9: timer cleared by disable
    sleepTicks = 8'd5;
    drive(7'b1110000);
    drive(7'b1110000);
    check(0, 1, 0, 0, "R4 sleep 5");
    drive(7'b1000010);
    drive(7'b1000010);
    drive(7'b0000000);
    check(0, 0, 0, 0, "R9 idle");
    drive(7'b1000000);
    drive(7'b1110000);
    drive(7'b1110000);
    check(0, 1, 0, 0, "R9 sleep again");
    for (int i = 0; i < 4; i++) drive(7'b1000010);
    check(0, 1, 0, 0, "R9 full interval after clear");
    drive(7'b1000010);
    check(1, 0, 0, 1, "R9 wake at tick 5");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule